// File: doc/BRIEF.md
# Byte-stream command dispatcher for a synchronous serial engine

The dispatcher reads a stream of command bytes from a valid/ready input and writes response bytes to a valid/ready output. Each command starts with one opcode byte, and some opcodes take further operand bytes. The dispatcher collects the operands and then acts on the command.

It handles these commands directly:
- It sets the value and direction of general-purpose lines in two groups, a low group of 8 lines and a high group of 4.
- It reads back the current pin levels.
- It switches an internal serial loopback on or off.
- It loads a 16-bit clock divisor.
- It stalls until a chosen line reaches a given level.
- It raises a flush pulse, which asks the transport to send pending response bytes at once.

An opcode with bit 7 clear is a bit-encoded shift job. The dispatcher does not shift bits itself. It starts a separate shift engine, hands that engine the input and response streams, and waits for the engine to report that it has finished. An unknown opcode with bit 7 set is reported to the host as a two-byte error. Driving `enable` low holds the whole block in reset. While held, every line is an input and no input byte is accepted.

Top module: `cmd_dispatch`

## Requirements
- R1: After reset, the block is in this state:
  - every line is an input (`pins_oe` = 0) and `pins_out` is 0;
  - `divisor` is 0 and `loopback` is 0;
  - `out_valid` is 0 and `in_ready` is 1.
- R2: Opcode 0x80 takes a value byte and then a direction byte for the low 8 lines.
  - Both take effect together, in the cycle after the direction byte is accepted.
  - `pins_out[7:0]` becomes the value and `pins_oe[7:0]` becomes the direction, where 1 means output.
  - The high lines are unchanged.
- R3: Opcode 0x82 takes a value byte and then a direction byte for the high 4 lines.
  - Bits [3:0] of each byte go to `pins_out[11:8]` and `pins_oe[11:8]`.
  - The low lines are unchanged.
- R4: Opcode 0x81 returns one byte equal to `pins_in[7:0]`, sampled when the opcode is accepted. Opcode 0x83 returns `{4'b0000, pins_in[11:8]}`.
- R5: Opcode 0x84 sets `loopback` to 1. Opcode 0x85 clears it to 0.
- R6: Opcode 0x86 takes a low byte and then a high byte. `divisor` becomes `{high, low}` in the cycle after the high byte is accepted.
- R7: Opcode 0x88 holds `in_ready` low until `pins_in[9]` is 1. Opcode 0x89 holds it low until `pins_in[9]` is 0. Accepting bytes resumes in the cycle after the level is seen.
- R8: Opcode 0x87 drives `flush_pulse` high for exactly one cycle, the cycle after the opcode is accepted.
- R9: Some opcodes have bit 7 set but are not in 0x80..0x89. For each such opcode, the output carries 0xFA and then the opcode byte, in that order.
- R10: An opcode with bit 7 clear starts a shift job.
  - `job_start` is high for one cycle, with `job_op` equal to the opcode.
  - Until `job_done` pulses, input bytes pass to `eng_rx_*` and engine bytes from `eng_tx_*` appear on `out_*`.
  - After `job_done`, the dispatcher decodes opcodes again.
- R11: While `enable` is 0:
  - `in_ready` is 0;
  - from the next clock edge, all state is at its reset value (`pins_oe` = 0, `divisor` = 0, `loopback` = 0).
- R12: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Low holds the block in reset |
| in_data | input | 8 | Command stream byte |
| in_valid | input | 1 | Command byte offered |
| in_ready | output | 1 | Command byte accepted this cycle |
| out_data | output | 8 | Response byte |
| out_valid | output | 1 | Response byte offered |
| out_ready | input | 1 | Host takes the response byte |
| pins_in | input | 12 | Sampled line levels; bit 9 is the wait line |
| pins_out | output | 12 | Stored line values |
| pins_oe | output | 12 | Line output enables |
| loopback | output | 1 | Serial out to serial in loopback on |
| divisor | output | 16 | Serial clock divisor |
| flush_pulse | output | 1 | One-cycle flush request |
| job_start | output | 1 | One-cycle shift job launch |
| job_op | output | 8 | Opcode of the launched shift job |
| job_done | input | 1 | Shift engine finished its job |
| eng_rx_data | output | 8 | Command byte passed to the engine |
| eng_rx_valid | output | 1 | Command byte offered to the engine |
| eng_rx_ready | input | 1 | Engine takes the command byte |
| eng_tx_data | input | 8 | Engine response byte |
| eng_tx_valid | input | 1 | Engine response byte offered |
| eng_tx_ready | output | 1 | Dispatcher takes the engine byte |

## Verification
The assertions assume that the host keeps `in_data` and `in_valid` steady until a byte is taken. They also assume that the engine raises `job_done` only during a job it was given, and that `pins_in` is already synchronised to `clk`.

The bench drives every input a fixed time after the falling clock edge and holds each offered byte until it sees `in_ready`. Its model shift engine signals completion only after its single response byte has been taken. The bench changes the wait line only while a stall is in progress.

// File: rtl/cmd_pkg.sv
package cmd_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] ERR_TAG = 8'hFA;

    typedef enum logic [3:0] {
        S_IDLE, S_OPER1, S_OPER2, S_RESP, S_ERR1, S_ERR2,
        S_WAIT_HI, S_WAIT_LO, S_SHIFT
    } state_e;

    typedef enum logic [3:0] {
        K_SHIFT, K_GPIO_LO, K_RD_LO, K_GPIO_HI, K_RD_HI, K_LOOP_ON,
        K_LOOP_OFF, K_DIV, K_FLUSH, K_WAIT_HI, K_WAIT_LO, K_BAD
    } op_kind_e;

    typedef struct packed {
        logic [BYTE_W-1:0] first;
        logic [BYTE_W-1:0] second;
    } oper_pair_t;

    function automatic op_kind_e classify(input logic [BYTE_W-1:0] op);
        op_kind_e k;
        if (!op[7]) begin
            k = K_SHIFT;
        end else begin
            case (op)
                8'h80:   k = K_GPIO_LO;
                8'h81:   k = K_RD_LO;
                8'h82:   k = K_GPIO_HI;
                8'h83:   k = K_RD_HI;
                8'h84:   k = K_LOOP_ON;
                8'h85:   k = K_LOOP_OFF;
                8'h86:   k = K_DIV;
                8'h87:   k = K_FLUSH;
                8'h88:   k = K_WAIT_HI;
                8'h89:   k = K_WAIT_LO;
                default: k = K_BAD;
            endcase
        end
        return k;
    endfunction

    function automatic logic takes_operands(input op_kind_e k);
        return (k == K_GPIO_LO) || (k == K_GPIO_HI) || (k == K_DIV);
    endfunction

endpackage

// File: rtl/cmd_classify.sv
module cmd_classify
    import cmd_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode,
    output op_kind_e          kind,
    output logic              has_oper
);
    always_comb begin
        kind     = classify(opcode);
        has_oper = takes_operands(kind);
    end
endmodule

// File: rtl/pin_bank.sv
module pin_bank
    import cmd_pkg::*;
#(
    parameter int NLO  = 8,
    parameter int NHI  = 4,
    parameter int DIVW = 16,
    localparam int NPIN = NLO + NHI
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_lo,
    input  logic [NLO-1:0]  lo_val,
    input  logic [NLO-1:0]  lo_dir,
    input  logic            wr_hi,
    input  logic [NHI-1:0]  hi_val,
    input  logic [NHI-1:0]  hi_dir,
    input  logic            wr_div,
    input  logic [DIVW-1:0] div_val,
    input  logic            loop_set,
    input  logic            loop_clr,
    output logic [NPIN-1:0] pins_out,
    output logic [NPIN-1:0] pins_oe,
    output logic [DIVW-1:0] divisor,
    output logic            loopback
);
    logic [NLO-1:0] lo_val_q, lo_dir_q;
    logic [NHI-1:0] hi_val_q, hi_dir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_val_q <= '0;
            lo_dir_q <= '0;
        end else if (wr_lo) begin
            lo_val_q <= lo_val;
            lo_dir_q <= lo_dir;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_val_q <= '0;
            hi_dir_q <= '0;
        end else if (wr_hi) begin
            hi_val_q <= hi_val;
            hi_dir_q <= hi_dir;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            divisor  <= '0;
            loopback <= 1'b0;
        end else begin
            if (wr_div)   divisor  <= div_val;
            if (loop_set) loopback <= 1'b1;
            else if (loop_clr) loopback <= 1'b0;
        end
    end

    assign pins_out = {hi_val_q, lo_val_q};
    assign pins_oe  = {hi_dir_q, lo_dir_q};
endmodule

// File: rtl/resp_slot.sv
module resp_slot
    import cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_data,
    output logic              free,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready
);
    assign free = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= load_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/cmd_dispatch.sv
module cmd_dispatch
    import cmd_pkg::*;
#(
    parameter int NLO      = 8,
    parameter int NHI      = 4,
    parameter int WAIT_BIT = 1,
    localparam int NPIN    = NLO + NHI,
    localparam int DIVW    = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready,
    input  logic [NPIN-1:0]   pins_in,
    output logic [NPIN-1:0]   pins_out,
    output logic [NPIN-1:0]   pins_oe,
    output logic              loopback,
    output logic [DIVW-1:0]   divisor,
    output logic              flush_pulse,
    output logic              job_start,
    output logic [BYTE_W-1:0] job_op,
    input  logic              job_done,
    output logic [BYTE_W-1:0] eng_rx_data,
    output logic              eng_rx_valid,
    input  logic              eng_rx_ready,
    input  logic [BYTE_W-1:0] eng_tx_data,
    input  logic              eng_tx_valid,
    output logic              eng_tx_ready
);
    logic       hold;
    state_e     state_q;
    op_kind_e   kind, kind_q;
    logic       has_oper;
    oper_pair_t oper;
    logic [BYTE_W-1:0] op_q, resp_q;
    logic       in_fire, commit, slot_free, slot_load;
    logic [BYTE_W-1:0] slot_data;
    logic       wait_lvl;

    assign hold     = rst || !enable;
    assign wait_lvl = pins_in[NLO + WAIT_BIT];

    cmd_classify u_cls (.opcode(in_data), .kind(kind), .has_oper(has_oper));

    always_comb begin
        case (state_q)
            S_IDLE, S_OPER1, S_OPER2: in_ready = enable;
            S_SHIFT:                  in_ready = enable && eng_rx_ready;
            default:                  in_ready = 1'b0;
        endcase
    end

    assign in_fire      = in_valid && in_ready;
    assign commit       = (state_q == S_OPER2) && in_fire;
    assign oper.first   = op_q;
    assign oper.second  = in_data;
    assign eng_rx_valid = (state_q == S_SHIFT) && in_valid;
    assign eng_rx_data  = in_data;
    assign eng_tx_ready = (state_q == S_SHIFT) && slot_free;

    always_comb begin
        slot_load = 1'b0;
        slot_data = resp_q;
        case (state_q)
            S_RESP:  slot_load = slot_free;
            S_ERR1:  begin slot_load = slot_free; slot_data = ERR_TAG; end
            S_ERR2:  begin slot_load = slot_free; slot_data = op_q;    end
            S_SHIFT: begin slot_load = slot_free && eng_tx_valid; slot_data = eng_tx_data; end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (hold) begin
            state_q     <= S_IDLE;
            kind_q      <= K_BAD;
            op_q        <= '0;
            resp_q      <= '0;
            flush_pulse <= 1'b0;
            job_start   <= 1'b0;
            job_op      <= '0;
        end else begin
            flush_pulse <= 1'b0;
            job_start   <= 1'b0;
            case (state_q)
                S_IDLE: if (in_fire) begin
                    kind_q <= kind;
                    op_q   <= in_data;
                    if (has_oper) begin
                        state_q <= S_OPER1;
                    end else begin
                        case (kind)
                            K_SHIFT: begin
                                job_start <= 1'b1;
                                job_op    <= in_data;
                                state_q   <= S_SHIFT;
                            end
                            K_RD_LO: begin
                                resp_q  <= pins_in[NLO-1:0];
                                state_q <= S_RESP;
                            end
                            K_RD_HI: begin
                                resp_q  <= BYTE_W'(pins_in[NPIN-1:NLO]);
                                state_q <= S_RESP;
                            end
                            K_FLUSH:   flush_pulse <= 1'b1;
                            K_WAIT_HI: state_q <= S_WAIT_HI;
                            K_WAIT_LO: state_q <= S_WAIT_LO;
                            K_BAD:     state_q <= S_ERR1;
                            default:   ;
                        endcase
                    end
                end
                S_OPER1: if (in_fire) begin
                    op_q    <= in_data;
                    state_q <= S_OPER2;
                end
                S_OPER2:   if (in_fire) state_q <= S_IDLE;
                S_RESP:    if (slot_free) state_q <= S_IDLE;
                S_ERR1:    if (slot_free) state_q <= S_ERR2;
                S_ERR2:    if (slot_free) state_q <= S_IDLE;
                S_WAIT_HI: if (wait_lvl)  state_q <= S_IDLE;
                S_WAIT_LO: if (!wait_lvl) state_q <= S_IDLE;
                S_SHIFT:   if (job_done)  state_q <= S_IDLE;
                default:   state_q <= S_IDLE;
            endcase
        end
    end

    pin_bank #(.NLO(NLO), .NHI(NHI), .DIVW(DIVW)) u_pins (
        .clk      (clk),
        .rst      (hold),
        .wr_lo    (commit && kind_q == K_GPIO_LO),
        .lo_val   (oper.first[NLO-1:0]),
        .lo_dir   (oper.second[NLO-1:0]),
        .wr_hi    (commit && kind_q == K_GPIO_HI),
        .hi_val   (oper.first[NHI-1:0]),
        .hi_dir   (oper.second[NHI-1:0]),
        .wr_div   (commit && kind_q == K_DIV),
        .div_val  ({oper.second, oper.first}),
        .loop_set (state_q == S_IDLE && in_fire && kind == K_LOOP_ON),
        .loop_clr (state_q == S_IDLE && in_fire && kind == K_LOOP_OFF),
        .pins_out (pins_out),
        .pins_oe  (pins_oe),
        .divisor  (divisor),
        .loopback (loopback)
    );

    resp_slot u_out (
        .clk       (clk),
        .rst       (hold),
        .load      (slot_load),
        .load_data (slot_data),
        .free      (slot_free),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_ready (out_ready)
    );
endmodule

// File: rtl/cmd_dispatch_chk.sv
module cmd_dispatch_chk
    import cmd_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        enable,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [7:0]  out_data,
    input logic [11:0] pins_oe,
    input logic        flush_pulse,
    input logic        job_start,
    input logic        wait_lvl,
    input state_e      st
);
    // R8
    p_flush_single_r8: assert property (@(posedge clk) disable iff (rst)
        flush_pulse |=> !flush_pulse);
    // R12
    p_out_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    // R11
    p_no_accept_r11: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !in_ready);
    // R11
    p_oe_cleared_r11: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (pins_oe == '0));
    // R10
    p_job_in_shift_r10: assert property (@(posedge clk) disable iff (rst)
        job_start |-> (st == S_SHIFT));
    // R10
    p_job_single_r10: assert property (@(posedge clk) disable iff (rst)
        job_start |=> !job_start);
    // R7
    p_wait_stall_r7: assert property (@(posedge clk) disable iff (rst)
        ((st == S_WAIT_HI && !wait_lvl) || (st == S_WAIT_LO && wait_lvl)) |-> !in_ready);
endmodule

bind cmd_dispatch cmd_dispatch_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .pins_oe     (pins_oe),
    .flush_pulse (flush_pulse),
    .job_start   (job_start),
    .wait_lvl    (wait_lvl),
    .st          (state_q)
);

// File: tb/tb_cmd_dispatch.sv
module tb_cmd_dispatch;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b1;
    logic [7:0]  in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [11:0] pins_in = '0;
    logic [11:0] pins_out, pins_oe;
    logic        loopback;
    logic [15:0] divisor;
    logic        flush_pulse, job_start;
    logic [7:0]  job_op;
    logic        job_done;
    logic [7:0]  eng_rx_data;
    logic        eng_rx_valid, eng_rx_ready;
    logic [7:0]  eng_tx_data;
    logic        eng_tx_valid, eng_tx_ready;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_dispatch dut (
        .clk(clk), .rst(rst), .enable(enable),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .pins_in(pins_in), .pins_out(pins_out), .pins_oe(pins_oe),
        .loopback(loopback), .divisor(divisor), .flush_pulse(flush_pulse),
        .job_start(job_start), .job_op(job_op), .job_done(job_done),
        .eng_rx_data(eng_rx_data), .eng_rx_valid(eng_rx_valid), .eng_rx_ready(eng_rx_ready),
        .eng_tx_data(eng_tx_data), .eng_tx_valid(eng_tx_valid), .eng_tx_ready(eng_tx_ready)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0] b;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_byte(input logic [7:0] b, input string tag);
        exp_t e;
        e.b = b;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        #2;
        if (!rst && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected response byte", {24'h0, out_data}, 32'hxxxx_xxxx);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, {24'h0, out_data}, {24'h0, e.b});
            end
        end
    end

    // model shift engine: takes two bytes, answers their XOR, then reports done
    logic       e_busy, e_txv, e_sent;
    logic [1:0] e_cnt;
    logic [7:0] e_acc, e_op;
    int         e_jobs;
    assign eng_rx_ready = e_busy && (e_cnt < 2);
    assign eng_tx_valid = e_txv;
    assign eng_tx_data  = e_acc;

    always @(posedge clk) begin
        if (rst) begin
            e_busy <= 1'b0; e_txv <= 1'b0; e_sent <= 1'b0; e_cnt <= '0;
            e_acc <= '0; e_op <= '0; e_jobs <= 0; job_done <= 1'b0;
        end else begin
            job_done <= 1'b0;
            if (job_start) begin
                e_busy <= 1'b1; e_cnt <= '0; e_acc <= '0; e_sent <= 1'b0;
                e_jobs <= e_jobs + 1; e_op <= job_op;
            end else if (e_busy) begin
                if (eng_rx_valid && eng_rx_ready) begin
                    e_acc <= e_acc ^ eng_rx_data;
                    e_cnt <= e_cnt + 1;
                end
                if (e_cnt == 2 && !e_txv && !e_sent) e_txv <= 1'b1;
                if (e_txv && eng_tx_ready) begin
                    e_txv  <= 1'b0;
                    e_sent <= 1'b1;
                end
                if (e_sent) begin
                    job_done <= 1'b1;
                    e_busy   <= 1'b0;
                    e_sent   <= 1'b0;
                end
            end
        end
    end

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 100 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R1 reset state
        check("R1 pins_oe", {20'h0, pins_oe}, 32'h0);
        check("R1 pins_out", {20'h0, pins_out}, 32'h0);
        check("R1 divisor", {16'h0, divisor}, 32'h0);
        check("R1 loopback", {31'h0, loopback}, 32'h0);
        check("R1 out_valid", {31'h0, out_valid}, 32'h0);
        check("R1 in_ready", {31'h0, in_ready}, 32'h1);

        // R2 low group write, commit together
        send(8'h80);
        send(8'hA5);
        check("R2 no early commit", {20'h0, pins_oe}, 32'h0);
        send(8'h3C);
        check("R2 low value", {24'h0, pins_out[7:0]}, 32'hA5);
        check("R2 low dir", {24'h0, pins_oe[7:0]}, 32'h3C);
        check("R2 high untouched", {28'h0, pins_oe[11:8]}, 32'h0);

        // R3 high group write
        send(8'h82);
        send(8'hF6);
        send(8'hF9);
        check("R3 high value", {28'h0, pins_out[11:8]}, 32'h6);
        check("R3 high dir", {28'h0, pins_oe[11:8]}, 32'h9);
        check("R3 low untouched", {24'h0, pins_out[7:0]}, 32'hA5);

        // R4 pin reads
        pins_in = 12'h5C3;
        expect_byte(8'hC3, "R4 read low");
        send(8'h81);
        expect_byte(8'h05, "R4 read high upper zero");
        send(8'h83);
        drain();

        // R5 loopback
        send(8'h84);
        check("R5 loopback on", {31'h0, loopback}, 32'h1);
        send(8'h85);
        check("R5 loopback off", {31'h0, loopback}, 32'h0);

        // R6 divisor
        send(8'h86);
        send(8'h34);
        send(8'h12);
        check("R6 divisor", {16'h0, divisor}, 32'h1234);

        // R8 flush pulse
        send(8'h87);
        check("R8 flush high", {31'h0, flush_pulse}, 32'h1);
        @(posedge clk);
        #1;
        check("R8 flush one cycle", {31'h0, flush_pulse}, 32'h0);

        // R9 bad opcodes
        expect_byte(8'hFA, "R9 error tag");
        expect_byte(8'h8C, "R9 error opcode");
        send(8'h8C);
        expect_byte(8'hFA, "R9 error tag");
        expect_byte(8'h93, "R9 error opcode");
        send(8'h93);
        expect_byte(8'hFA, "R9 error tag");
        expect_byte(8'hFF, "R9 error opcode");
        send(8'hFF);
        drain();

        // R7 wait high then wait low
        pins_in[9] = 1'b0;
        send(8'h88);
        repeat (3) @(negedge clk);
        #1;
        check("R7 stall on high wait", {31'h0, in_ready}, 32'h0);
        pins_in[9] = 1'b1;
        @(posedge clk);
        #1;
        check("R7 resume after high", {31'h0, in_ready}, 32'h1);
        send(8'h89);
        repeat (3) @(negedge clk);
        #1;
        check("R7 stall on low wait", {31'h0, in_ready}, 32'h0);
        pins_in[9] = 1'b0;
        @(posedge clk);
        #1;
        check("R7 resume after low", {31'h0, in_ready}, 32'h1);

        // R10 shift job handoff
        send(8'h39);
        check("R10 job_start", {31'h0, job_start}, 32'h1);
        check("R10 job_op", {24'h0, job_op}, 32'h39);
        expect_byte(8'h33, "R10 engine response");
        send(8'h11);
        send(8'h22);
        drain();
        check("R10 job count", e_jobs, 32'd1);
        pins_in[7:0] = 8'h4D;
        expect_byte(8'h4D, "R10 decode after done");
        send(8'h81);
        drain();

        // R12 output backpressure
        out_ready = 1'b0;
        pins_in[7:0] = 8'h7E;
        send(8'h81);
        repeat (3) @(negedge clk);
        #1;
        check("R12 held valid", {31'h0, out_valid}, 32'h1);
        check("R12 held data", {24'h0, out_data}, 32'h7E);
        repeat (2) @(negedge clk);
        #1;
        check("R12 still held", {24'h0, out_data}, 32'h7E);
        expect_byte(8'h7E, "R12 released byte");
        @(negedge clk);
        out_ready = 1'b1;
        drain();

        // R11 disable holds reset
        @(negedge clk);
        enable = 1'b0;
        #1;
        check("R11 no accept", {31'h0, in_ready}, 32'h0);
        @(posedge clk);
        #1;
        check("R11 lines inputs", {20'h0, pins_oe}, 32'h0);
        check("R11 divisor cleared", {16'h0, divisor}, 32'h0);
        @(negedge clk);
        enable = 1'b1;
        pins_in[7:0] = 8'h2B;
        expect_byte(8'h2B, "R11 works after enable");
        send(8'h81);
        drain();

        check("R9 scoreboard empty", exp_q.size(), 32'd0);
        summary();
    end
endmodule